// File: doc/BRIEF.md
# Descending Word Stack Controller

This block runs a last-in-first-out store of 16-bit words kept in an on-chip memory. It holds a byte-addressed stack pointer covering a reserved region of `DEPTH` words that begins at byte address `BASE_ADDR`. The stack grows toward lower addresses. A push first moves the pointer down by two bytes and then stores the word at the new pointer. A pop first reads the word at the pointer and then moves the pointer up by two. When the stack is empty, the pointer sits at the first byte above the region.

A peek reads an entry lying a byte offset above the current top without moving the pointer. After three pushes, offset 4 returns the first word that was pushed. The block takes one request per cycle. It rejects any push that would overflow, any pop that would underflow and any peek that reaches outside the live entries, and it flags each rejection with a one-cycle error pulse. Pop and peek data come back one cycle after the request, because the memory read port is synchronous. An initialise request resets the pointer to the empty position.

Top module: `stk_ctrl`

## Requirements
- R1: After reset, and in the cycle after an initialise request, `sp_o` equals `BASE_ADDR + 2*DEPTH` (0x60 by default), `empty_o` is 1 and `full_o` is 0. Initialise takes priority over every other request in the same cycle.
- R2: An accepted push lowers `sp_o` by 2 in the next cycle and stores `push_data_i` at the word at the new pointer.
- R3: A push while `sp_o == BASE_ADDR` is ignored: `sp_o` is unchanged and `err_o` is 1 for exactly the next cycle.
- R4: An accepted pop sets `rd_valid_o` to 1 and `rd_data_o` to the word at the old pointer in the next cycle, and raises `sp_o` by 2.
- R5: A pop on an empty stack is ignored: `sp_o` is unchanged, `rd_valid_o` stays 0 and `err_o` is 1 for the next cycle.
- R6: A peek with offset `k` returns, in the next cycle, the word at byte address `sp_o + k` with `rd_valid_o` at 1. Bit 0 of the offset is ignored, so offsets 4 and 5 read the same word. `sp_o` does not change.
- R7: A peek whose aligned address is at or above the empty-stack address returns `rd_data_o` of 0 with `rd_valid_o` at 1, and `err_o` is 1 for that cycle.
- R8: When push and pop are requested together, the push is performed and the pop is dropped, so no read data is returned.
- R9: When pop and peek are requested together (without push or initialise), only the pop is performed.
- R10: `full_o` is 1 exactly when `sp_o == BASE_ADDR`, and `empty_o` is 1 exactly when `sp_o` is at the empty-stack address.
- R11: `rd_data_o` is 0 in every cycle in which `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Reset the pointer to the empty position |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| peek_i | input | 1 | Peek request |
| peek_off_i | input | ADDR_W | Byte offset above the top for a peek |
| push_data_i | input | DATA_W | Word to push |
| rd_data_o | output | DATA_W | Pop or peek data |
| rd_valid_o | output | 1 | `rd_data_o` holds a result |
| sp_o | output | ADDR_W | Current byte stack pointer |
| full_o | output | 1 | No room for another push |
| empty_o | output | 1 | No entries held |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
If the pointer is off by one word, it appears on `sp_o` and on the flags in the very next cycle. It also appears on `rd_data_o` at the next pop or peek, because the wrong slot is read. A write sent to the wrong memory index does not show up at once. It surfaces only when that entry is read back, so the bench pushes distinct words and reads each of them back through both pops and peeks. A wrong full or empty boundary shows up as a missing or spurious `err_o` pulse at the first request made at the edge of the region.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_INIT,
    OP_PUSH,
    OP_POP,
    OP_PEEK
  } stk_op_e;
endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/stk_arb.sv
module stk_arb (
  input  logic             init_req,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             peek_req,
  output stk_pkg::stk_op_e op_o
);
  import stk_pkg::*;

  // Fixed priority: initialise, push, pop, peek.
  always_comb begin
    if (init_req)      op_o = OP_INIT;
    else if (push_req) op_o = OP_PUSH;
    else if (pop_req)  op_o = OP_POP;
    else if (peek_req) op_o = OP_PEEK;
    else               op_o = OP_NONE;
  end
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[ridx];
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned BASE_ADDR = 64,
  localparam int unsigned IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_pkg::stk_op_e  op_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic              re_o,
  output logic [IDX_W-1:0]  ridx_o,
  output logic              err_o,
  output logic              rvalid_o,
  output logic              zero_o
);
  import stk_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W:0]   TOP_X  = (ADDR_W+1)'(BASE_ADDR + 2 * DEPTH);
  localparam logic [ADDR_W-1:0] TOP_A  = TOP_X[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(2);

  logic [ADDR_W-1:0] sp_q, sp_d, sp_dec, sp_inc, off_al;
  logic [ADDR_W:0]   peek_sum;
  logic              peek_bad, sp_en;
  logic              err_d, rv_d, zero_d;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rel;
    rel = (a - BASE_A) >> 1;
    return IDX_W'(rel);
  endfunction

  assign full_o   = (sp_q == BASE_A);
  assign empty_o  = (sp_q == TOP_A);
  assign sp_dec   = sp_q - STEP;
  assign sp_inc   = sp_q + STEP;
  assign off_al   = off_i & ~ADDR_W'(1);
  assign peek_sum = {1'b0, sp_q} + {1'b0, off_al};
  assign peek_bad = (peek_sum >= TOP_X);

  // Next-state decode
  always_comb begin
    sp_d   = sp_q;
    sp_en  = 1'b0;
    we_o   = 1'b0;
    re_o   = 1'b0;
    err_d  = 1'b0;
    rv_d   = 1'b0;
    zero_d = 1'b0;
    widx_o = idx_of(sp_dec);
    ridx_o = idx_of(sp_q);
    unique case (op_i)
      OP_INIT: begin
        sp_d  = TOP_A;
        sp_en = 1'b1;
      end
      OP_PUSH: begin
        if (full_o) begin
          err_d = 1'b1;
        end else begin
          sp_d  = sp_dec;
          sp_en = 1'b1;
          we_o  = 1'b1;
        end
      end
      OP_POP: begin
        if (empty_o) begin
          err_d = 1'b1;
        end else begin
          re_o  = 1'b1;
          rv_d  = 1'b1;
          sp_d  = sp_inc;
          sp_en = 1'b1;
        end
      end
      OP_PEEK: begin
        ridx_o = idx_of(peek_sum[ADDR_W-1:0]);
        rv_d   = 1'b1;
        if (peek_bad) begin
          err_d  = 1'b1;
          zero_d = 1'b1;
        end else begin
          re_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= TOP_A;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o    <= 1'b0;
      rvalid_o <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      err_o    <= err_d;
      rvalid_o <= rv_d;
      zero_o   <= zero_d;
    end
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned BASE_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              peek_i,
  input  logic [ADDR_W-1:0] peek_off_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              rst_n_sync;
  stk_pkg::stk_op_e  op;
  logic              we, re, zero_q;
  logic [IDX_W-1:0]  widx, ridx;
  logic [DATA_W-1:0] mem_rdata;

  stk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  stk_arb u_arb (
    .init_req (init_i),
    .push_req (push_i),
    .pop_req  (pop_i),
    .peek_req (peek_i),
    .op_o     (op)
  );

  stk_ptr #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (DEPTH),
    .BASE_ADDR (BASE_ADDR)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .op_i     (op),
    .off_i    (peek_off_i),
    .sp_o     (sp_o),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .we_o     (we),
    .widx_o   (widx),
    .re_o     (re),
    .ridx_o   (ridx),
    .err_o    (err_o),
    .rvalid_o (rd_valid_o),
    .zero_o   (zero_q)
  );

  stk_mem #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .we    (we),
    .widx  (widx),
    .wdata (push_data_i),
    .re    (re),
    .ridx  (ridx),
    .rdata (mem_rdata)
  );

  assign rd_data_o = (rd_valid_o && !zero_q) ? mem_rdata : '0;
endmodule

// File: rtl/stk_ctrl_chk.sv
module stk_ctrl_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned BASE_ADDR = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_i,
  input logic              push_i,
  input logic              pop_i,
  input logic              peek_i,
  input logic [ADDR_W-1:0] peek_off_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(BASE_ADDR + 2 * DEPTH);
  localparam logic [ADDR_W-1:0] TWO    = ADDR_W'(2);

  logic do_push, do_pop, do_peek, peek_oob;
  logic [ADDR_W:0] psum;

  assign do_push  = push_i && !init_i;
  assign do_pop   = pop_i && !push_i && !init_i;
  assign do_peek  = peek_i && !pop_i && !push_i && !init_i;
  assign psum     = {1'b0, sp_o} + {1'b0, peek_off_i & ~ADDR_W'(1)};
  assign peek_oob = (psum >= {1'b0, TOP_A});

  p_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (sp_o == TOP_A) && empty_o && !full_o);

  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !full_o) |=> (sp_o == $past(sp_o) - TWO) && !err_o);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && full_o) |=> $stable(sp_o) && err_o);

  p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !empty_o) |=> rd_valid_o && (sp_o == $past(sp_o) + TWO));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && empty_o) |=> $stable(sp_o) && err_o && !rd_valid_o);

  p_peek_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_peek |=> $stable(sp_o) && rd_valid_o);

  p_peek_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_peek && peek_oob) |=> err_o && (rd_data_o == '0));

  p_push_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !init_i) |=> !rd_valid_o);

  p_pop_over_peek_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && peek_i && !empty_o) |=> (sp_o == $past(sp_o) + TWO));

  p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o) && (sp_o >= BASE_A) && (sp_o <= TOP_A));

  p_quiet_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_data_o == '0));

  p_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(push_i || pop_i || peek_i));
endmodule

bind stk_ctrl stk_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .DEPTH     (DEPTH),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .init_i      (init_i),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .peek_i      (peek_i),
  .peek_off_i  (peek_off_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .sp_o        (sp_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .err_o       (err_o)
);

// File: tb/stk_ctrl_test.sv
module stk_ctrl_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int BASE   = 64;
  localparam int TOP    = BASE + 2 * DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 1'b0, push_i = 1'b0, pop_i = 1'b0, peek_i = 1'b0;
  logic [ADDR_W-1:0] peek_off_i = '0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic rd_valid_o, full_o, empty_o, err_o;
  logic [ADDR_W-1:0] sp_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int msp;
  int mm [DEPTH];

  always #5 clk = ~clk;

  stk_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (DEPTH), .BASE_ADDR (BASE)
  ) uut (
    .clk (clk), .rst_n (rst_n), .init_i (init_i), .push_i (push_i),
    .pop_i (pop_i), .peek_i (peek_i), .peek_off_i (peek_off_i),
    .push_data_i (push_data_i), .rd_data_o (rd_data_o),
    .rd_valid_o (rd_valid_o), .sp_o (sp_o), .full_o (full_o),
    .empty_o (empty_o), .err_o (err_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag, input int e_err, input int e_rv, input int e_rd);
    chk(tag, "sp", int'(sp_o), msp);
    chk(tag, "err", int'(err_o), e_err);
    chk(tag, "rvalid", int'(rd_valid_o), e_rv);
    chk(tag, "rdata", int'(rd_data_o), e_rd);
    chk("R10", "full", int'(full_o), (msp == BASE) ? 1 : 0);
    chk("R10", "empty", int'(empty_o), (msp == TOP) ? 1 : 0);
    if (e_rv == 0) chk("R11", "rdata idle", int'(rd_data_o), 0);
  endtask

  // Called at a falling edge; one request per cycle, result read at the next falling edge.
  task automatic do_op(input string tag, input bit ini, input bit psh, input bit pp,
                       input bit pk, input int off, input int data);
    int e_err, e_rv, e_rd, a;
    e_err = 0; e_rv = 0; e_rd = 0;
    init_i = ini; push_i = psh; pop_i = pp; peek_i = pk;
    peek_off_i = ADDR_W'(off); push_data_i = DATA_W'(data);
    if (ini) begin
      msp = TOP;
    end else if (psh) begin
      if (msp == BASE) e_err = 1;
      else begin msp -= 2; mm[(msp - BASE) / 2] = data; end
    end else if (pp) begin
      if (msp == TOP) e_err = 1;
      else begin e_rv = 1; e_rd = mm[(msp - BASE) / 2]; msp += 2; end
    end else if (pk) begin
      a = msp + (off & ~1);
      e_rv = 1;
      if (a >= TOP) e_err = 1;
      else e_rd = mm[(a - BASE) / 2];
    end
    @(posedge clk);
    @(negedge clk);
    init_i = 0; push_i = 0; pop_i = 0; peek_i = 0;
    compare_all(tag, e_err, e_rv, e_rd);
  endtask

  initial begin
    msp = TOP;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    compare_all("R1", 0, 0, 0);

    do_op("R5", 0, 0, 1, 0, 0, 0);           // underflow on empty
    do_op("R7", 0, 0, 0, 1, 0, 0);           // peek on empty
    do_op("R2", 0, 1, 0, 0, 0, 16'hA1A1);
    do_op("R2", 0, 1, 0, 0, 0, 16'hB2B2);
    do_op("R2", 0, 1, 0, 0, 0, 16'hC3C3);
    do_op("R6", 0, 0, 0, 1, 4, 0);           // first pushed word
    do_op("R6", 0, 0, 0, 1, 2, 0);
    do_op("R6", 0, 0, 0, 1, 5, 0);           // bit 0 ignored
    do_op("R6", 0, 0, 0, 1, 0, 0);
    do_op("R7", 0, 0, 0, 1, 6, 0);           // at empty address
    do_op("R7", 0, 0, 0, 1, 200, 0);         // far beyond
    do_op("R4", 0, 0, 1, 0, 0, 0);
    do_op("R8", 0, 1, 1, 0, 0, 16'hD4D4);    // push wins
    do_op("R9", 0, 0, 1, 1, 2, 0);           // pop wins over peek
    do_op("R11", 0, 0, 0, 0, 0, 0);          // idle
    do_op("R1", 1, 1, 1, 1, 0, 16'hEEEE);    // init wins
    for (int i = 0; i < DEPTH; i++)
      do_op("R2", 0, 1, 0, 0, 0, 16'h1000 + i * 16'h0111);
    do_op("R3", 0, 1, 0, 0, 0, 16'hFFFF);    // overflow
    do_op("R3", 0, 1, 1, 0, 0, 16'h5555);    // overflow with pop dropped
    do_op("R6", 0, 0, 0, 1, 2 * (DEPTH - 1), 0);
    do_op("R7", 0, 0, 0, 1, 2 * DEPTH, 0);
    for (int i = 0; i < DEPTH; i++)
      do_op("R4", 0, 0, 1, 0, 0, 0);
    do_op("R5", 0, 0, 1, 0, 0, 0);
    do_op("R11", 0, 0, 0, 0, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule